// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from an external three-wire serial EEPROM. A one-cycle request carrying a word address starts a read. The block raises chip select and shifts out the read opcode and the address on the data-in pin, one serial clock period per bit. It then clocks sixteen bits back in from the data-out pin and drops chip select. The captured word appears on a data output, together with a single-cycle done pulse.

A device-type select input chooses between a 6-bit address for the smaller part and an 8-bit address for the larger one. A divider input sets how many system clocks every serial phase lasts, so one design serves fast and slow parts. Each level that the block places on the serial clock or data-in pin is held for one full phase before the next change.

Top module: `sprom_word_reader`

## Requirements
- R1: After reset, chip select, serial clock, data-in, busy and done are all 0, and the read data output is 0.
- R2: A request seen in idle is accepted at that clock edge. From the next cycle, chip select is 1 and busy is 1 until the done cycle. Every serial phase lasts H system clocks, where H is the divider value, and a divider value of 0 acts as 1. The first phase is a select phase with the serial clock and data-in low.
- R3: When the device select is 0, the command is 9 bits: opcode 110 (binary) followed by the low 6 bits of the address, most significant bit first.
- R4: When the device select is 1, the command is 11 bits: opcode 110 followed by the low 8 bits of the address, most significant bit first.
- R5: Each command bit is shown on data-in for one phase with the serial clock low. The serial clock is then raised for one phase while data-in stays unchanged.
- R6: After the last command bit, one phase follows with the serial clock low and data-in low. Then readout begins.
- R7: Sixteen data bits are read, most significant bit first. For each bit, the serial clock is high for one phase and then low for one phase. Data-out is sampled on the last system clock of the high phase.
- R8: After the 16th low phase, chip select, busy and the serial clock are 0 in the same cycle. Done is 1 for exactly that one cycle, and the read data output holds the captured word from that cycle until the next done.
- R9: A request that arrives while busy is 1 has no effect on the pin sequence or on the word returned.
- R10: Data-in is 0 in every phase that is not a command bit phase.
- R11: Chip select stays 1 without a gap from the select phase through the last data low phase, and falls only in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | One-cycle read request |
| reqAddr | input | 8 | Word address; the low 6 bits are used when wideSel is 0 |
| wideSel | input | 1 | Device select: 0 for a 6-bit address, 1 for an 8-bit address |
| phaseDiv | input | 8 | System clocks per serial phase (0 treated as 1) |
| doutIn | input | 1 | Serial data from the EEPROM |
| csOut | output | 1 | Chip select to the EEPROM |
| sclkOut | output | 1 | Serial clock to the EEPROM |
| dinOut | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | High while a read is in progress |
| done | output | 1 | One-cycle pulse when the word is ready |
| rdData | output | 16 | Word returned by the last read |

## Verification
Each output is due at a fixed cycle count after the accepting edge. The pins show the select level one cycle after acceptance. Every later level lasts H cycles. Done arrives (2 + 2N + 32)·H + 1 cycles after acceptance, where N is 9 or 11. The bench builds this expected per-cycle sequence from the requirements when it issues the request. It compares the pins, busy and done at every falling clock edge, so each value is sampled half a cycle after the edge that produced it. It also checks the word at the done cycle. A behavioural EEPROM model answers on data-out from the command bits it actually receives, so a wrong address or bit order shows up as a wrong word.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_GAP,
    ST_DAT_HI,
    ST_DAT_LO
  } sprom_state_t;

  typedef struct packed {
    logic load;      // latch command and address at accept
    logic shiftCmd;  // advance to the next command bit
    logic capture;   // sample data-out into the word register
    logic finish;    // publish the captured word
  } dpStrobe_t;

endpackage

// File: rtl/sprom_ctrl.sv
module sprom_ctrl
  import sprom_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DATA_W    = 16,
  parameter int OP_W      = 3,
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             wideSel,
  input  logic [DIV_W-1:0] phaseDiv,
  output dpStrobe_t        strobe,
  output logic             csOut,
  output logic             sclkOut,
  output logic             dinEn,
  output logic             busy,
  output logic             done
);

  localparam int MAX_BITS = (OP_W + WIDE_AW > DATA_W) ? OP_W + WIDE_AW : DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] NARROW_LEN = CNT_W'(OP_W + NARROW_AW);
  localparam logic [CNT_W-1:0] WIDE_LEN   = CNT_W'(OP_W + WIDE_AW);
  localparam logic [CNT_W-1:0] DATA_LEN   = CNT_W'(DATA_W);

  sprom_state_t     state;
  logic [DIV_W-1:0] holdReg;
  logic [DIV_W-1:0] phaseCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] cmdLen;
  logic [DIV_W-1:0] holdNext;
  logic             accept;
  logic             phaseEnd;
  logic             lastBit;

  assign holdNext = (phaseDiv == '0) ? DIV_W'(1) : phaseDiv;
  assign accept   = (state == ST_IDLE) && reqValid;
  assign phaseEnd = (state != ST_IDLE) && (phaseCnt == DIV_W'(1));
  assign lastBit  = (bitsLeft == CNT_W'(1));
  assign cmdLen   = wideSel ? WIDE_LEN : NARROW_LEN;

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.shiftCmd = phaseEnd && (state == ST_CMD_HI) && !lastBit;
    strobe.capture  = phaseEnd && (state == ST_DAT_HI);
    strobe.finish   = phaseEnd && (state == ST_DAT_LO) && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      holdReg  <= DIV_W'(1);
      phaseCnt <= '0;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (accept) begin
        state    <= ST_SEL;
        holdReg  <= holdNext;
        phaseCnt <= holdNext;
        bitsLeft <= cmdLen;
      end else if (state != ST_IDLE) begin
        if (!phaseEnd) begin
          phaseCnt <= phaseCnt - DIV_W'(1);
        end else begin
          phaseCnt <= holdReg;
          unique case (state)
            ST_SEL:    state <= ST_CMD_LO;
            ST_CMD_LO: state <= ST_CMD_HI;
            ST_CMD_HI: begin
              if (lastBit) begin
                state <= ST_GAP;
              end else begin
                state    <= ST_CMD_LO;
                bitsLeft <= bitsLeft - CNT_W'(1);
              end
            end
            ST_GAP: begin
              state    <= ST_DAT_HI;
              bitsLeft <= DATA_LEN;
            end
            ST_DAT_HI: state <= ST_DAT_LO;
            ST_DAT_LO: begin
              if (lastBit) begin
                state <= ST_IDLE;
              end else begin
                state    <= ST_DAT_HI;
                bitsLeft <= bitsLeft - CNT_W'(1);
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign csOut   = (state != ST_IDLE);
  assign busy    = (state != ST_IDLE);
  assign sclkOut = (state == ST_CMD_HI) || (state == ST_DAT_HI);
  assign dinEn   = (state == ST_CMD_LO) || (state == ST_CMD_HI);

endmodule

// File: rtl/sprom_dpath.sv
module sprom_dpath
  import sprom_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          OP_W      = 3,
  parameter int          NARROW_AW = 6,
  parameter int          WIDE_AW   = 8,
  parameter logic [OP_W-1:0] OPCODE = 3'b110
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               wideSel,
  input  logic [WIDE_AW-1:0] reqAddr,
  input  logic               dinEn,
  input  logic               doutIn,
  output logic               dinOut,
  output logic [DATA_W-1:0]  rdData
);

  localparam int CMD_W = OP_W + WIDE_AW;
  localparam int PAD_W = WIDE_AW - NARROW_AW;

  logic [CMD_W-1:0]  cmdReg;
  logic [CMD_W-1:0]  cmdInit;
  logic [DATA_W-1:0] wordReg;

  // Command is left aligned so the next bit to send always sits in the MSB.
  generate
    if (PAD_W > 0) begin : g_pad
      assign cmdInit = wideSel ? {OPCODE, reqAddr}
                               : {OPCODE, reqAddr[NARROW_AW-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign cmdInit = {OPCODE, reqAddr};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      wordReg <= '0;
      rdData  <= '0;
    end else begin
      if (strobe.load)          cmdReg  <= cmdInit;
      else if (strobe.shiftCmd) cmdReg  <= {cmdReg[CMD_W-2:0], 1'b0};
      if (strobe.capture)       wordReg <= {wordReg[DATA_W-2:0], doutIn};
      if (strobe.finish)        rdData  <= wordReg;
    end
  end

  assign dinOut = dinEn & cmdReg[CMD_W-1];

endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
  import sprom_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DATA_W    = 16,
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [WIDE_AW-1:0] reqAddr,
  input  logic               wideSel,
  input  logic [DIV_W-1:0]   phaseDiv,
  input  logic               doutIn,
  output logic               csOut,
  output logic               sclkOut,
  output logic               dinOut,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdData
);

  localparam int OP_W = 3;

  dpStrobe_t strobe;
  logic      dinEn;

  sprom_ctrl #(
    .DIV_W(DIV_W), .DATA_W(DATA_W), .OP_W(OP_W),
    .NARROW_AW(NARROW_AW), .WIDE_AW(WIDE_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wideSel(wideSel),
    .phaseDiv(phaseDiv), .strobe(strobe), .csOut(csOut), .sclkOut(sclkOut),
    .dinEn(dinEn), .busy(busy), .done(done)
  );

  sprom_dpath #(
    .DATA_W(DATA_W), .OP_W(OP_W), .NARROW_AW(NARROW_AW),
    .WIDE_AW(WIDE_AW), .OPCODE(3'b110)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wideSel(wideSel),
    .reqAddr(reqAddr), .dinEn(dinEn), .doutIn(doutIn),
    .dinOut(dinOut), .rdData(rdData)
  );

endmodule

// File: rtl/sprom_word_reader_chk.sv
module sprom_word_reader_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              csOut,
  input logic              sclkOut,
  input logic              dinOut,
  input logic              done,
  input logic [DATA_W-1:0] rdData
);

  // R8: done lasts exactly one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done coincides with the fall of chip select
  a_r8_done_at_deselect: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!csOut && $past(csOut)));

  // R11: chip select falls only in the done cycle
  a_r11_cs_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csOut) |-> done);

  // R2: chip select rises only after a request
  a_r2_cs_after_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csOut) |-> $past(reqValid));

  // R10: data-in is low while deselected
  a_r10_din_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !csOut |-> !dinOut);

  // R5: serial clock never toggles while deselected
  a_r5_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |-> csOut);

  // R5: data-in does not move during a high serial clock phase
  a_r5_din_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut && $past(sclkOut)) |-> $stable(dinOut));

  // R8: the returned word changes only with done
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> done);

endmodule

bind sprom_word_reader sprom_word_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .csOut(csOut),
  .sclkOut(sclkOut), .dinOut(dinOut), .done(done), .rdData(rdData)
);

// File: tb/sprom_word_reader_test.sv
`timescale 1ns/1ps
module sprom_word_reader_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic        wideSel = 1'b0;
  logic [7:0]  phaseDiv = 8'd1;
  logic        doutIn = 1'b0;
  logic        csOut, sclkOut, dinOut, busy, done;
  logic [15:0] rdData;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sprom_word_reader uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .wideSel(wideSel), .phaseDiv(phaseDiv), .doutIn(doutIn),
    .csOut(csOut), .sclkOut(sclkOut), .dinOut(dinOut),
    .busy(busy), .done(done), .rdData(rdData)
  );

  function automatic logic [15:0] memWord(input logic [7:0] a);
    return 16'((a * 16'h9E37) ^ 16'h3C5A);
  endfunction

  // Behavioural EEPROM: collects command bits on rising serial clock,
  // then presents data bits MSB first on later rising edges.
  int          mCnt = 0;
  int          mLen = 9;
  logic [10:0] mCmd = '0;
  logic        mPrevSk = 1'b0;
  always @(negedge clk) begin
    if (!csOut) begin
      mCnt   = 0;
      mCmd   = '0;
      doutIn = 1'b0;
    end else if (sclkOut && !mPrevSk) begin
      if (mCnt < mLen) begin
        mCmd = {mCmd[9:0], dinOut};
      end else begin
        doutIn = memWord((mLen == 11) ? mCmd[7:0] : {2'b00, mCmd[5:0]})[15 - (mCnt - mLen)];
      end
      mCnt++;
    end
    mPrevSk = sclkOut;
  end

  logic [4:0] expQ[$];   // {cs, sclk, din, busy, done}

  task automatic pushPhase(input logic sk, input logic di, input int h);
    for (int k = 0; k < h; k++) expQ.push_back({1'b1, sk, di, 1'b1, 1'b0});
  endtask

  task automatic doRead(input logic [7:0] a, input logic w, input logic [7:0] div,
                        input bit intrude, input string tag);
    int h = (div == 0) ? 1 : int'(div);
    int n = w ? 11 : 9;
    logic [10:0] cmd = w ? {3'b110, a} : {3'b110, a[5:0], 2'b00};
    logic [7:0] effA = w ? a : {2'b00, a[5:0]};
    logic [15:0] expWord = memWord(effA);
    int idx = 0;
    expQ.delete();
    pushPhase(1'b0, 1'b0, h);                        // select phase (R2)
    for (int b = 0; b < n; b++) begin                // R3/R4/R5
      pushPhase(1'b0, cmd[10-b], h);
      pushPhase(1'b1, cmd[10-b], h);
    end
    pushPhase(1'b0, 1'b0, h);                        // R6 gap
    for (int b = 0; b < 16; b++) begin               // R7
      pushPhase(1'b1, 1'b0, h);
      pushPhase(1'b0, 1'b0, h);
    end
    expQ.push_back(5'b00001);                        // R8 done cycle
    expQ.push_back(5'b00000);                        // back to idle
    mLen = n;
    @(negedge clk);
    reqAddr = a; wideSel = w; phaseDiv = div; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (expQ.size() > 0) begin
      logic [4:0] e = expQ.pop_front();
      logic [4:0] got = {csOut, sclkOut, dinOut, busy, done};
      tests++;
      if (got !== e) begin
        fails++;
        $display("FAIL %s R2/R3/R5/R10/R11 cycle %0d pins got %b exp %b", tag, idx, got, e);
      end
      if (e[0]) begin
        tests++;
        if (rdData !== expWord) begin
          fails++;
          $display("FAIL %s R7/R8 word got %h exp %h", tag, rdData, expWord);
        end
      end
      if (intrude && idx == 5) begin   // R9: request while busy
        reqAddr = ~a; wideSel = ~w; reqValid = 1'b1;
      end else begin
        reqValid = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    tests++;
    if (rdData !== expWord) begin       // R8: word is held after done
      fails++;
      $display("FAIL %s R8 held word got %h exp %h", tag, rdData, expWord);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if ({csOut, sclkOut, dinOut, busy, done} !== 5'b0 || rdData !== 16'h0) begin
      fails++;
      $display("FAIL R1 reset got %b/%h exp 00000/0000",
               {csOut, sclkOut, dinOut, busy, done}, rdData);
    end
    rstN = 1'b1;
    @(negedge clk);
    doRead(8'h15, 1'b0, 8'd1, 1'b0, "R3_narrow_div1");
    doRead(8'hC3, 1'b1, 8'd3, 1'b0, "R4_wide_div3");
    doRead(8'hFF, 1'b0, 8'd0, 1'b0, "R3_R2_narrow_mask_div0");
    doRead(8'h00, 1'b1, 8'd2, 1'b1, "R9_wide_intrude");
    doRead(8'hA6, 1'b1, 8'd1, 1'b1, "R9_R4_wide_div1");
    doRead(8'h2A, 1'b0, 8'd4, 1'b0, "R6_R7_narrow_div4");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule